// File: doc/BRIEF.md
# Send Queue to Transmit Descriptor Ring Translator

This block takes message entries from a per-endpoint send queue and turns each one into entries on a circular transmit descriptor ring. The ring is shared by every endpoint and is read by a frame DMA engine. A message arrives as one or more beats, one beat for each user buffer. The first beat also carries the address of a prepared header buffer and the total message length.

The first descriptor of a frame points its first pointer at the header buffer and its second pointer at the first user buffer. As a result, no payload is ever copied. Each further buffer takes a chained descriptor of its own. Ownership of a multi-descriptor frame passes to the DMA engine only when the first descriptor is rewritten with its ownership bit set, and that rewrite happens after the rest of the chain is valid.

A message longer than the payload limit is discarded as a whole. When the queue runs dry and at least one frame has been placed since the last notification, the block raises a single poll-demand pulse for the whole batch.

Top module: `sq_ring_xlate`

## Requirements
- R1: The first beat of an accepted message writes a descriptor with first flag 1. Its ptr1 is the header pointer, its ptr2 is the beat's buffer pointer, and its length is the beat's buffer length.
- R2: Every further beat of the message writes a chained descriptor with first flag 0, own 1, ptr1 set to the beat's buffer pointer and ptr2 set to 0. Its last flag is 1 only on the final beat.
- R3: A one-beat message writes exactly one descriptor, with own, first and last all set to 1.
- R4: The first descriptor of a multi-beat message is written with own 0. In the cycle right after the final chained descriptor is written, the same index is written again with own 1, first 1, last 0 and the original pointers and length.
- R5: Descriptor indices start at 0 after reset and advance by one for each new descriptor, wrapping from RING_SLOTS-1 to 0. The ownership rewrite does not advance the index.
- R6: Once RING_SLOTS descriptors are outstanding, sq_ready stays low. Each one-cycle dma_free pulse returns one descriptor, and acceptance resumes after that.
- R7: A first beat whose message length exceeds MAX_PAYLOAD (1500) writes no descriptor and raises drop_pulse for one cycle. The remaining beats of that message are consumed without writes. A length of exactly 1500 is accepted.
- R8: tx_poll is a one-cycle pulse. It is raised once the queue has no valid entry and every placed frame has been handed over. A batch of back-to-back messages gives one pulse, and no pulse occurs if nothing was placed since the last one.
- R9: After reset, sq_ready is 1 and desc_we, tx_poll and drop_pulse are 0.
- R10: The descriptor write for a beat accepted at a clock edge is visible in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_valid | input | 1 | Send-queue beat present |
| sq_ready | output | 1 | Beat accepted at the clock edge when high with sq_valid |
| sq_first | input | 1 | Beat is the first of a message |
| sq_last | input | 1 | Beat is the last of a message |
| sq_msg_len | input | LENW | Total message bytes (sampled on first beat) |
| sq_hdr_ptr | input | AW | Header buffer address (sampled on first beat) |
| sq_buf_ptr | input | AW | User buffer address of this beat |
| sq_buf_len | input | LENW | User buffer bytes of this beat |
| dma_free | input | 1 | One descriptor returned by the DMA engine |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | IW | Ring slot written |
| desc_own | output | 1 | Ownership bit: 1 hands the slot to the DMA engine |
| desc_first | output | 1 | Descriptor opens a frame |
| desc_last | output | 1 | Descriptor closes a frame |
| desc_len | output | LENW | Byte count of the user buffer |
| desc_ptr1 | output | AW | First buffer pointer |
| desc_ptr2 | output | AW | Second buffer pointer |
| tx_poll | output | 1 | Poll-demand pulse for the DMA engine |
| drop_pulse | output | 1 | Oversize message discarded |

## Verification
Every descriptor write is due exactly one cycle after its beat is accepted. The ownership rewrite follows one cycle later still, and drop_pulse shares the write's one-cycle latency. The scoreboard stamps each expected write with the simulation time at which it must appear and compares it at the falling edge of that cycle, so a write that comes early, late or in the wrong order is reported. The poll pulse has no fixed slot, so the bench lowers sq_valid, waits several cycles and then compares the number of pulses seen against the number of batches. The stall is checked by sampling sq_ready on every cycle between filling the ring and returning a slot.

// File: rtl/sqx_pkg.sv
package sqx_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_COMMIT = 2'd1,
    ST_DROP   = 2'd2
  } sqx_state_e;

  // Successor of a ring slot, wrapping at the slot count.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned slots);
    return (idx + 1 == slots) ? 0 : idx + 1;
  endfunction

  // Message length rule for the frame payload limit.
  function automatic logic len_too_big(input int unsigned len, input int unsigned limit);
    return len > limit;
  endfunction

endpackage

// File: rtl/sqx_ring_track.sv
module sqx_ring_track #(
  parameter int RING_SLOTS = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          free,
  output logic [IW-1:0] head,
  output logic          full
);
  import sqx_pkg::*;

  localparam bit POW2 = (RING_SLOTS == (1 << IW));

  logic [IW:0]   count_q;
  logic [IW-1:0] head_q;
  logic [IW-1:0] head_n;

  generate
    if (POW2) begin : g_pow2
      assign head_n = head_q + 1'b1;
    end else begin : g_wrap
      assign head_n = IW'(ring_next(32'(head_q), RING_SLOTS));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc) head_q <= head_n;
      count_q <= count_q + (IW+1)'(alloc) - (IW+1)'(free);
    end
  end

  assign head = head_q;
  assign full = (32'(count_q) == RING_SLOTS);
endmodule

// File: rtl/sqx_seq.sv
module sqx_seq #(
  parameter int AW = 32,
  parameter int LENW = 16,
  parameter int IW = 3,
  parameter int MAX_PAYLOAD = 1500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sq_valid,
  output logic            sq_ready,
  input  logic            sq_first,
  input  logic            sq_last,
  input  logic [LENW-1:0] sq_msg_len,
  input  logic [AW-1:0]   sq_hdr_ptr,
  input  logic [AW-1:0]   sq_buf_ptr,
  input  logic [LENW-1:0] sq_buf_len,
  input  logic            full,
  input  logic [IW-1:0]   head,
  output logic            alloc,
  output logic            dropping,
  output logic            desc_we,
  output logic [IW-1:0]   desc_idx,
  output logic            desc_own,
  output logic            desc_first,
  output logic            desc_last,
  output logic [LENW-1:0] desc_len,
  output logic [AW-1:0]   desc_ptr1,
  output logic [AW-1:0]   desc_ptr2,
  output logic            tx_poll,
  output logic            drop_pulse
);
  import sqx_pkg::*;

  sqx_state_e      state_q;
  logic            in_frame_q, dirty_q;
  logic [IW-1:0]   f_idx_q;
  logic [AW-1:0]   f_hdr_q, f_buf_q;
  logic [LENW-1:0] f_len_q;

  // Named events used by the sequencer and the checker.
  logic take, too_big, start_ok, start_drop, chain_beat, batch_done;

  assign sq_ready   = (state_q == ST_DROP) || (state_q == ST_RUN && !full);
  assign take       = sq_valid && sq_ready;
  assign too_big    = len_too_big(32'(sq_msg_len), MAX_PAYLOAD);
  assign start_ok   = take && state_q == ST_RUN && sq_first && !too_big;
  assign start_drop = take && state_q == ST_RUN && sq_first && too_big;
  assign chain_beat = take && state_q == ST_RUN && !sq_first && in_frame_q;
  assign batch_done = state_q == ST_RUN && !sq_valid && !in_frame_q && dirty_q;
  assign alloc      = start_ok || chain_beat;
  assign dropping   = state_q == ST_DROP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      in_frame_q <= 1'b0;
      dirty_q    <= 1'b0;
      f_idx_q    <= '0;
      f_hdr_q    <= '0;
      f_buf_q    <= '0;
      f_len_q    <= '0;
      desc_we    <= 1'b0;
      desc_idx   <= '0;
      desc_own   <= 1'b0;
      desc_first <= 1'b0;
      desc_last  <= 1'b0;
      desc_len   <= '0;
      desc_ptr1  <= '0;
      desc_ptr2  <= '0;
      tx_poll    <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      desc_we    <= 1'b0;
      tx_poll    <= 1'b0;
      drop_pulse <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (start_ok) begin
            desc_we    <= 1'b1;
            desc_idx   <= head;
            desc_own   <= sq_last;
            desc_first <= 1'b1;
            desc_last  <= sq_last;
            desc_len   <= sq_buf_len;
            desc_ptr1  <= sq_hdr_ptr;
            desc_ptr2  <= sq_buf_ptr;
            f_idx_q    <= head;
            f_hdr_q    <= sq_hdr_ptr;
            f_buf_q    <= sq_buf_ptr;
            f_len_q    <= sq_buf_len;
            in_frame_q <= !sq_last;
            if (sq_last) dirty_q <= 1'b1;
          end else if (start_drop) begin
            drop_pulse <= 1'b1;
            in_frame_q <= 1'b0;
            if (!sq_last) state_q <= ST_DROP;
          end else if (chain_beat) begin
            desc_we    <= 1'b1;
            desc_idx   <= head;
            desc_own   <= 1'b1;
            desc_first <= 1'b0;
            desc_last  <= sq_last;
            desc_len   <= sq_buf_len;
            desc_ptr1  <= sq_buf_ptr;
            desc_ptr2  <= '0;
            if (sq_last) begin
              in_frame_q <= 1'b0;
              state_q    <= ST_COMMIT;
            end
          end else if (batch_done) begin
            tx_poll <= 1'b1;
            dirty_q <= 1'b0;
          end
        end
        ST_COMMIT: begin
          desc_we    <= 1'b1;
          desc_idx   <= f_idx_q;
          desc_own   <= 1'b1;
          desc_first <= 1'b1;
          desc_last  <= 1'b0;
          desc_len   <= f_len_q;
          desc_ptr1  <= f_hdr_q;
          desc_ptr2  <= f_buf_q;
          dirty_q    <= 1'b1;
          state_q    <= ST_RUN;
        end
        ST_DROP: begin
          if (take && sq_last) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sq_ring_xlate.sv
module sq_ring_xlate #(
  parameter int AW = 32,
  parameter int LENW = 16,
  parameter int RING_SLOTS = 8,
  parameter int MAX_PAYLOAD = 1500,
  localparam int IW = (RING_SLOTS > 1) ? $clog2(RING_SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sq_valid,
  output logic            sq_ready,
  input  logic            sq_first,
  input  logic            sq_last,
  input  logic [LENW-1:0] sq_msg_len,
  input  logic [AW-1:0]   sq_hdr_ptr,
  input  logic [AW-1:0]   sq_buf_ptr,
  input  logic [LENW-1:0] sq_buf_len,
  input  logic            dma_free,
  output logic            desc_we,
  output logic [IW-1:0]   desc_idx,
  output logic            desc_own,
  output logic            desc_first,
  output logic            desc_last,
  output logic [LENW-1:0] desc_len,
  output logic [AW-1:0]   desc_ptr1,
  output logic [AW-1:0]   desc_ptr2,
  output logic            tx_poll,
  output logic            drop_pulse
);
  logic          alloc_w;
  logic          full_w;
  logic          drop_w;
  logic [IW-1:0] head_w;

  sqx_ring_track #(.RING_SLOTS(RING_SLOTS), .IW(IW)) u_track (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_w), .free(dma_free),
    .head(head_w), .full(full_w)
  );

  sqx_seq #(.AW(AW), .LENW(LENW), .IW(IW), .MAX_PAYLOAD(MAX_PAYLOAD)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sq_valid(sq_valid), .sq_ready(sq_ready), .sq_first(sq_first), .sq_last(sq_last),
    .sq_msg_len(sq_msg_len), .sq_hdr_ptr(sq_hdr_ptr), .sq_buf_ptr(sq_buf_ptr),
    .sq_buf_len(sq_buf_len), .full(full_w), .head(head_w), .alloc(alloc_w),
    .dropping(drop_w), .desc_we(desc_we), .desc_idx(desc_idx), .desc_own(desc_own),
    .desc_first(desc_first), .desc_last(desc_last), .desc_len(desc_len),
    .desc_ptr1(desc_ptr1), .desc_ptr2(desc_ptr2), .tx_poll(tx_poll),
    .drop_pulse(drop_pulse)
  );
endmodule

// File: rtl/sq_ring_xlate_chk.sv
module sq_ring_xlate_chk #(
  parameter int AW = 32,
  parameter int LENW = 16,
  parameter int RING_SLOTS = 8,
  parameter int MAX_PAYLOAD = 1500,
  parameter int IW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sq_valid,
  input logic            sq_ready,
  input logic            sq_first,
  input logic [LENW-1:0] sq_msg_len,
  input logic            dma_free,
  input logic            desc_we,
  input logic [IW-1:0]   desc_idx,
  input logic            desc_own,
  input logic            desc_first,
  input logic            desc_last,
  input logic [AW-1:0]   desc_ptr2,
  input logic            tx_poll,
  input logic            drop_pulse,
  input logic            drop_w
);
  logic          big, start, new_slot;
  logic [IW:0]   outstanding;
  logic [IW-1:0] exp_head;

  assign big      = 32'(sq_msg_len) > MAX_PAYLOAD;
  assign start    = sq_valid && sq_ready && sq_first && !drop_w;
  assign new_slot = desc_we && !(desc_first && desc_own && !desc_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      exp_head    <= '0;
    end else begin
      outstanding <= outstanding + (IW+1)'(new_slot) - (IW+1)'(dma_free);
      if (new_slot) exp_head <= (32'(exp_head) == RING_SLOTS - 1) ? '0 : exp_head + 1'b1;
    end
  end

  assert_write_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !big) |=> (desc_we && desc_first));

  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && big) |=> (drop_pulse && !desc_we));

  assert_chain_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && !desc_first) |-> (desc_own && desc_ptr2 == '0));

  assert_own_after_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_first && desc_own && !desc_last) |->
      ($past(desc_we) && $past(desc_last) && !$past(desc_first)));

  assert_index_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    new_slot |-> (desc_idx == exp_head));

  assert_stall_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(outstanding) == RING_SLOTS && !drop_w) |-> !sq_ready);

  assert_poll_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |=> !tx_poll);

  assert_poll_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> !desc_we);
endmodule

bind sq_ring_xlate sq_ring_xlate_chk #(
  .AW(AW), .LENW(LENW), .RING_SLOTS(RING_SLOTS), .MAX_PAYLOAD(MAX_PAYLOAD), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_ready(sq_ready),
  .sq_first(sq_first), .sq_msg_len(sq_msg_len), .dma_free(dma_free),
  .desc_we(desc_we), .desc_idx(desc_idx), .desc_own(desc_own),
  .desc_first(desc_first), .desc_last(desc_last), .desc_ptr2(desc_ptr2),
  .tx_poll(tx_poll), .drop_pulse(drop_pulse), .drop_w(drop_w)
);

// File: tb/sq_ring_xlate_test.sv
`timescale 1ns/1ps
module sq_ring_xlate_test;
  localparam int AW = 32;
  localparam int LENW = 16;
  localparam int SLOTS = 8;
  localparam int LIMIT = 1500;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sq_valid = 1'b0, sq_first = 1'b0, sq_last = 1'b0, dma_free = 1'b0;
  logic [LENW-1:0] sq_msg_len = '0, sq_buf_len = '0;
  logic [AW-1:0] sq_hdr_ptr = '0, sq_buf_ptr = '0;
  logic sq_ready, desc_we, desc_own, desc_first, desc_last, tx_poll, drop_pulse;
  logic [IW-1:0] desc_idx;
  logic [LENW-1:0] desc_len;
  logic [AW-1:0] desc_ptr1, desc_ptr2;

  always #2.5 clk = ~clk;

  sq_ring_xlate #(.AW(AW), .LENW(LENW), .RING_SLOTS(SLOTS), .MAX_PAYLOAD(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_ready(sq_ready),
    .sq_first(sq_first), .sq_last(sq_last), .sq_msg_len(sq_msg_len),
    .sq_hdr_ptr(sq_hdr_ptr), .sq_buf_ptr(sq_buf_ptr), .sq_buf_len(sq_buf_len),
    .dma_free(dma_free), .desc_we(desc_we), .desc_idx(desc_idx), .desc_own(desc_own),
    .desc_first(desc_first), .desc_last(desc_last), .desc_len(desc_len),
    .desc_ptr1(desc_ptr1), .desc_ptr2(desc_ptr2), .tx_poll(tx_poll),
    .drop_pulse(drop_pulse)
  );

  typedef struct {
    int       idx;
    bit       own, first, last;
    logic [AW-1:0] p1, p2;
    int       len;
    realtime  due;
    string    req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  int poll_seen = 0, drop_seen = 0, exp_poll = 0, exp_drop = 0;
  int head_m = 0, outstanding = 0, f_idx = 0, f_len = 0;
  logic [AW-1:0] f_hdr = '0, f_buf = '0;
  bit m_in = 0, m_drop = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void push(int idx, bit own, bit first, bit last,
                               logic [AW-1:0] p1, logic [AW-1:0] p2, int len,
                               realtime due, string req);
    item_t it;
    it.idx = idx; it.own = own; it.first = first; it.last = last;
    it.p1 = p1; it.p2 = p2; it.len = len; it.due = due; it.req = req;
    exp_q.push_back(it);
  endfunction

  // Monitor: compares every descriptor write against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_poll) poll_seen++;
      if (drop_pulse) drop_seen++;
      if (desc_we) begin
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected descriptor write idx", int'(desc_idx), -1);
        end else begin
          item_t e;
          realtime dt;
          e = exp_q.pop_front();
          dt = $realtime - e.due;
          check(int'(desc_idx) == e.idx, e.req, "desc_idx (R5)", int'(desc_idx), e.idx);
          check({desc_own, desc_first, desc_last} == {e.own, e.first, e.last}, e.req,
                "own/first/last", int'({desc_own, desc_first, desc_last}),
                int'({e.own, e.first, e.last}));
          check(desc_ptr1 == e.p1 && desc_ptr2 == e.p2, e.req, "ptr1^ptr2",
                int'(desc_ptr1 ^ desc_ptr2), int'(e.p1 ^ e.p2));
          check(int'(desc_len) == e.len, e.req, "desc_len", int'(desc_len), e.len);
          check(dt < 0.1 && dt > -0.1, "R10", "write time ps", int'($realtime * 1000),
                int'(e.due * 1000));
        end
      end
    end
  end

  // Driver: presents one beat, waits for acceptance, updates the model.
  task automatic send_beat(bit f, bit l, logic [AW-1:0] h, logic [AW-1:0] b,
                           int blen, int mlen, string req);
    bit r;
    realtime t;
    @(negedge clk);
    sq_valid = 1'b1; sq_first = f; sq_last = l;
    sq_hdr_ptr = h; sq_buf_ptr = b; sq_buf_len = LENW'(blen); sq_msg_len = LENW'(mlen);
    forever begin
      #1;
      r = sq_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    t = $realtime;
    if (f) begin
      if (mlen > LIMIT) begin
        exp_drop++;
        m_drop = !l;
        m_in = 0;
      end else begin
        push(head_m, l, 1'b1, l, h, b, blen, t + 2.5, l ? "R3" : "R1");
        f_idx = head_m; f_hdr = h; f_buf = b; f_len = blen;
        head_m = (head_m + 1) % SLOTS;
        outstanding++;
        m_in = !l;
      end
    end else if (m_drop) begin
      if (l) m_drop = 0;
    end else if (m_in) begin
      push(head_m, 1'b1, 1'b0, l, b, '0, blen, t + 2.5, "R2");
      head_m = (head_m + 1) % SLOTS;
      outstanding++;
      if (l) begin
        push(f_idx, 1'b1, 1'b1, 1'b0, f_hdr, f_buf, f_len, t + 7.5, "R4");
        m_in = 0;
      end
    end
  endtask

  task automatic idle_check(int add_poll);
    @(negedge clk);
    sq_valid = 1'b0;
    repeat (6) @(negedge clk);
    exp_poll += add_poll;
    check(poll_seen == exp_poll, "R8", "poll pulses", poll_seen, exp_poll);
    check(drop_seen == exp_drop, "R7", "drop pulses", drop_seen, exp_drop);
  endtask

  task automatic free_one();
    @(negedge clk);
    dma_free = 1'b1;
    @(negedge clk);
    dma_free = 1'b0;
    outstanding--;
  endtask

  task automatic free_all();
    while (outstanding > 0) free_one();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: state after reset
    check(sq_ready == 1'b1, "R9", "sq_ready", int'(sq_ready), 1);
    check(desc_we == 1'b0, "R9", "desc_we", int'(desc_we), 0);
    check(tx_poll == 1'b0 && drop_pulse == 1'b0, "R9", "poll|drop",
          int'(tx_poll | drop_pulse), 0);

    // R3, R8: one single-buffer frame
    send_beat(1, 1, 32'h1000, 32'h8000, 64, 64, "R3");
    idle_check(1);

    // R1, R2, R4: three-buffer message
    send_beat(1, 0, 32'h1100, 32'h9000, 100, 300, "R1");
    send_beat(0, 0, 32'h0, 32'h9100, 120, 300, "R2");
    send_beat(0, 1, 32'h0, 32'h9200, 80, 300, "R2");
    idle_check(1);
    free_all();

    // R8: batch of back-to-back frames gives a single poll
    send_beat(1, 1, 32'h1200, 32'hA000, 40, 40, "R8");
    send_beat(1, 1, 32'h1300, 32'hA100, 41, 41, "R8");
    send_beat(1, 0, 32'h1400, 32'hA200, 50, 90, "R8");
    send_beat(0, 1, 32'h0, 32'hA300, 40, 90, "R8");
    send_beat(1, 1, 32'h1500, 32'hA400, 42, 42, "R8");
    idle_check(1);
    free_all();

    // R7: oversize messages dropped, limit accepted
    send_beat(1, 1, 32'h1600, 32'hB000, 1501, 1501, "R7");
    idle_check(0);
    send_beat(1, 0, 32'h1700, 32'hB100, 1000, 3000, "R7");
    send_beat(0, 0, 32'h0, 32'hB200, 1000, 3000, "R7");
    send_beat(0, 1, 32'h0, 32'hB300, 1000, 3000, "R7");
    idle_check(0);
    send_beat(1, 1, 32'h1800, 32'hB400, 1500, 1500, "R7");
    idle_check(1);
    free_all();

    // R5, R6: fill the ring, stall, free one, wrap
    for (int i = 0; i < SLOTS; i++)
      send_beat(1, 1, 32'h2000 + 32'(i), 32'hC000 + 32'(16 * i), 10 + i, 10 + i, "R5");
    fork
      send_beat(1, 1, 32'h2100, 32'hD000, 77, 77, "R6");
      begin
        repeat (4) begin
          @(negedge clk);
          #1;
          check(sq_ready == 1'b0, "R6", "sq_ready while full", int'(sq_ready), 0);
        end
        free_one();
      end
    join
    idle_check(1);
    free_all();

    check(exp_q.size() == 0, "R10", "writes still pending", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule